// File: doc/BRIEF.md
# Sequential Radix-2 Booth Signed Multiplier

This block multiplies two signed two's-complement operands of a configurable width by recoding the multiplier two bits at a time. Each recoded pair selects one of three actions on a running accumulator: add the multiplicand, subtract it, or leave the accumulator alone. After the action, the accumulator, the multiplier register and one history bit shift right together as one arithmetic unit. The loop retires one multiplier bit per clock. After as many steps as the operand has bits, the double-width product sits in the accumulator and multiplier register.

A client raises `start` for one cycle with both operands while the block is idle. The block raises `busy` for the whole calculation and pulses `done` once the result is ready. The product stays on the output until the next accepted start. Negative operands need no pre- or post-correction. The accumulator is one bit wider than an operand, so subtracting the most negative multiplicand keeps its sign.

Top module: `booth_seq_mult`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to idle: after that edge `busy` is 0, `done` is 0 and `product` is 0. This holds even in the middle of a calculation.
- R2: A rising edge with `start` high while `busy` is low accepts the operands. `busy` is 1 after that edge.
- R3: Take the edge that accepts the operands as edge 0. The block performs exactly OPW recode-and-shift steps on edges 1 to OPW. `done` rises after edge OPW and `busy` falls after the same edge.
- R4: `done` is high for exactly one cycle per accepted start, and is never high together with `busy`.
- R5: When `done` is high, `product` equals the signed product of `mcand` and `mplier` as captured at acceptance, as a 2*OPW-bit two's-complement value. For OPW=4 this covers all 256 operand pairs, for example 5 × −3 = 8'b11110001 and −8 × −8 = 64.
- R6: A `start` raised while `busy` is high is ignored. The running calculation is neither restarted nor reloaded, and its result matches the first operands.
- R7: While the block is idle and `start` is low, `product` holds its last value, including on the cycles after `done` falls.
- R8: Each step takes the pair {multiplier LSB, history bit}. Pair 2'b10 subtracts the multiplicand, 2'b01 adds it, and 2'b00 and 2'b11 leave the accumulator unchanged. The history bit is 0 when a calculation starts.
- R9: A zero operand, on either side, gives a zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiplication; honoured only while idle |
| mcand | input | OPW | Signed multiplicand |
| mplier | input | OPW | Signed multiplier |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse: product valid |
| product | output | 2*OPW | Signed product {accumulator, multiplier register} |

## Verification
The accepting edge counts as edge 0. `busy` is due one edge later. `done` and the final `product` are due exactly OPW edges after acceptance, and `done` is gone one edge after that. The bench drives inputs on falling edges and samples there. After lowering `start`, it counts falling edges until `done` appears and requires the count to equal OPW. It then checks on the next falling edge that the pulse has ended and that the product is unchanged. A second start pulsed mid-calculation and a reset applied mid-calculation are checked at those same sample points.

// File: rtl/booth_pkg.sv
// Shared types for the radix-2 Booth multiplier.
// Assumes: nothing beyond IEEE 1800-2017.
package booth_pkg;

    // Action selected by one recoded multiplier pair
    typedef enum logic [1:0] {
        BOP_SKIP = 2'd0,
        BOP_ADD  = 2'd1,
        BOP_SUB  = 2'd2
    } booth_op_e;

endpackage

// File: rtl/booth_recode.sv
// Radix-2 Booth recoder: maps {multiplier LSB, history bit} onto an action.
// Assumes: history bit is 0 at the start of each calculation.
module booth_recode
    import booth_pkg::*;
(
    input  logic      lsb_i,
    input  logic      hist_i,
    output booth_op_e op_o
);

    // Decode the bit pair into add, subtract or skip (R8)
    always_comb begin
        unique case ({lsb_i, hist_i})
            2'b10:   op_o = BOP_SUB;
            2'b01:   op_o = BOP_ADD;
            default: op_o = BOP_SKIP;
        endcase
    end

endmodule

// File: rtl/booth_addsub.sv
// Accumulator adder/subtractor, one bit wider than the operand.
// Assumes: acc_i is already sign-extended to W+1 bits.
module booth_addsub
    import booth_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W:0]   acc_i,
    input  logic [W-1:0] mcand_i,
    input  booth_op_e    op_i,
    output logic [W:0]   res_o
);

    localparam int XW = W + 1;

    logic [XW-1:0] mext;

    // Sign-extend the multiplicand so its most negative value survives negation
    always_comb mext = {mcand_i[W-1], mcand_i};

    // Apply the selected action at W+1 bits
    always_comb begin
        unique case (op_i)
            BOP_ADD: res_o = acc_i + mext;
            BOP_SUB: res_o = acc_i - mext;
            default: res_o = acc_i;
        endcase
    end

endmodule

// File: rtl/booth_ctrl.sv
// Sequencer: accepts a start while idle, runs W steps, then pulses done.
// Assumes: synchronous active-low reset; start is ignored while busy.
module booth_ctrl #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] STEPS = CW'(W);
    localparam logic [CW-1:0] LAST  = CW'(1);

    logic [CW-1:0] cnt_q;

    // Accept only while idle; iterate on every busy cycle
    always_comb begin
        load_o = start_i & ~busy_o;
        step_o = busy_o;
    end

    // Sequence counter, busy flag and one-cycle done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (load_o) begin
                cnt_q  <= STEPS;
                busy_o <= 1'b1;
            end else if (busy_o) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == LAST) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/booth_seq_mult.sv
// Sequential radix-2 Booth multiplier for signed OPW-bit operands.
// Holds a W+1-bit accumulator, the multiplier register, a history bit and the
// captured multiplicand; one recode-and-shift step per clock.
// Assumes: synchronous active-low reset; product valid when done pulses and
// held until the next accepted start.
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [OPW-1:0]     mcand,
    input  logic [OPW-1:0]     mplier,
    output logic               busy,
    output logic               done,
    output logic [2*OPW-1:0]   product
);

    localparam int AW = OPW + 1;

    logic [AW-1:0]  acc_q;
    logic [OPW-1:0] qr_q;
    logic           hist_q;
    logic [OPW-1:0] mcand_q;
    logic           load;
    logic           step;
    booth_op_e      op;
    logic [AW-1:0]  sum;

    booth_ctrl #(.W(OPW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy),
        .done_o  (done)
    );

    booth_recode u_recode (
        .lsb_i  (qr_q[0]),
        .hist_i (hist_q),
        .op_o   (op)
    );

    booth_addsub #(.W(OPW)) u_addsub (
        .acc_i   (acc_q),
        .mcand_i (mcand_q),
        .op_i    (op),
        .res_o   (sum)
    );

    // Load operands, then shift {acc, qr, hist} right arithmetically each step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            qr_q    <= '0;
            hist_q  <= 1'b0;
            mcand_q <= '0;
        end else if (load) begin
            acc_q   <= '0;
            qr_q    <= mplier;
            hist_q  <= 1'b0;
            mcand_q <= mcand;
        end else if (step) begin
            acc_q  <= {sum[AW-1], sum[AW-1:1]};
            qr_q   <= {sum[0], qr_q[OPW-1:1]};
            hist_q <= qr_q[0];
        end
    end

    // Product is the low accumulator bits joined to the multiplier register
    always_comb product = {acc_q[OPW-1:0], qr_q};

endmodule

// File: rtl/booth_seq_mult_chk.sv
// Property checker for booth_seq_mult, attached by bind.
// Assumes: same clock and synchronous active-low reset as the design.
module booth_seq_mult_chk #(
    parameter int W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [W-1:0]     mcand,
    input logic [W-1:0]     mplier,
    input logic             busy,
    input logic             done,
    input logic [2*W-1:0]   product
);

    localparam int CW = $clog2(W + 2);

    logic [CW-1:0]  steps_q;
    logic [2*W-1:0] ref_q;

    // Count edges since acceptance and hold a reference product
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steps_q <= '0;
            ref_q   <= '0;
        end else if (start && !busy) begin
            steps_q <= '0;
            ref_q   <= $signed({{W{mcand[W-1]}}, mcand}) * $signed({{W{mplier[W-1]}}, mplier});
        end else if (busy) begin
            steps_q <= steps_q + 1'b1;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!busy && !done)); // R1
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
    AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n) done |-> (steps_q == CW'(W))); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R4
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R4
    AST_PRODUCT_OK: assert property (@(posedge clk) disable iff (!rst_n) done |-> (product == ref_q)); // R5
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (busy && steps_q < CW'(W - 1)) |=> busy); // R6
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start && $past(rst_n)) |=> $stable(product)); // R7

endmodule

bind booth_seq_mult booth_seq_mult_chk #(.W(OPW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mcand   (mcand),
    .mplier  (mplier),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/booth_seq_mult_bench.sv
// Self-checking bench: exhaustive 4-bit sweep plus timing, ignore and reset cases.
module booth_seq_mult_bench;

    localparam int W  = 4;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  mcand = '0;
    logic [W-1:0]  mplier = '0;
    logic          busy;
    logic          done;
    logic [PW-1:0] product;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    booth_seq_mult #(.OPW(W)) u_booth_seq_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mcand   (mcand),
        .mplier  (mplier),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    // 250 MHz clock
    always #2 clk = ~clk;

    // Record one check and report any mismatch
    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b);
        int sa;
        int sb;
        int p;
        sa = a[W-1] ? int'(a) - (1 << W) : int'(a);
        sb = b[W-1] ? int'(b) - (1 << W) : int'(b);
        p  = sa * sb;
        return p[PW-1:0];
    endfunction

    // Run one multiplication; optionally pulse start again mid-calculation
    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke, input string tag);
        int n;
        logic [PW-1:0] exp;
        logic [PW-1:0] held;
        exp = ref_prod(a, b);
        @(negedge clk);
        start = 1'b1; mcand = a; mplier = b;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2 busy after accept", busy, 1);
        n = 0;
        while (done !== 1'b1 && n < 50) begin
            if (poke && n == 1) begin
                start = 1'b1; mcand = ~a; mplier = ~b;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check(n == W, "R3 steps to done", n, W);
        check(busy === 1'b0, "R4 busy low with done", busy, 0);
        check(product === exp, tag, product, exp);
        held = product;
        @(negedge clk);
        check(done === 1'b0, "R4 done one cycle", done, 0);
        @(negedge clk);
        check(product === held, "R7 product held idle", product, held);
    endtask

    // Watchdog: a hung run is a failure but still reaches the summary
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R1 reset idle", {busy, done}, 0);
        check(product === '0, "R1 reset product", product, 0);
        rst_n = 1'b1;

        // Named corners
        run_mul(4'd5, 4'b1101, 1'b0, "R5 5 x -3");
        run_mul(4'b1000, 4'b1000, 1'b0, "R5 -8 x -8");
        run_mul(4'd0, 4'b1011, 1'b0, "R9 zero multiplicand");
        run_mul(4'b0110, 4'd0, 1'b0, "R9 zero multiplier");
        run_mul(4'b0111, 4'b0101, 1'b0, "R8 alternating multiplier");
        run_mul(4'b1001, 4'b1111, 1'b0, "R8 all-ones multiplier");

        // Start while busy is ignored
        run_mul(4'b0011, 4'b1010, 1'b1, "R6 restart ignored");

        // Exhaustive sweep
        for (int i = 0; i < (1 << W); i++) begin
            for (int j = 0; j < (1 << W); j++) begin
                run_mul(W'(i), W'(j), 1'b0, "R5 sweep product");
            end
        end

        // Reset in mid-calculation
        @(negedge clk);
        start = 1'b1; mcand = 4'd7; mplier = 4'd7;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R1 reset mid-run", {busy, done}, 0);
        check(product === '0, "R1 reset mid-run product", product, 0);
        rst_n = 1'b1;
        repeat (W + 2) @(negedge clk);
        check(done === 1'b0, "R1 no done after reset", done, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule